// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block gathers sixteen interrupt request lines for a processor and delivers one 8-bit vector for each acknowledge. Two eight-line priority cores do the work. The master core owns lines 0 to 7 and the slave core owns lines 8 to 15. The local index of a line inside its core is the low three bits of the line number. Before a line reaches its core, a per-core trigger register decides how the line is conditioned. An edge-triggered line latches a request only when its input rises. A level-triggered line sets its request while the input is high and clears it when the input is low.

The slave core reports whether it has an unblocked candidate. That flag is continuously ORed with raw input 2 and fed into master line 2, where it passes through the same trigger rules as any other line. When the processor acknowledges and the master's candidate is line 2, the acknowledge is passed on to the slave, which supplies the vector. The cascade input is then held low for that cycle, so a later slave request shows up as a fresh edge.

Software reaches six byte locations through a plain address, data and write-strobe port with combinational read data. Each core's configuration sequencer has four states. `ST_RUN` is normal operation. A command write with bit 4 set moves any state to `ST_BASE`. The first data write moves `ST_BASE` to `ST_CASC`. The next data write moves `ST_CASC` to `ST_MODE` if the initialising command had bit 0 set, and to `ST_RUN` otherwise. A data write moves `ST_MODE` to `ST_RUN`.

Top module: `cascade_irq16`

## Requirements
- R1: After reset, both mask registers read 0xFF, both trigger registers read 0x00, `intr` is low and `ack_valid` is low.
- R2: The address map is fixed. Address 0 is the master command location and address 1 the master data location. Address 2 is the slave command location and address 3 the slave data location. Addresses 4 and 5 hold the master and slave trigger registers, which read back what was written; a trigger bit of 1 means level-triggered.
- R3: On an edge-triggered line, a request is latched only on a low-to-high input change. An acknowledge clears the request. An input that stays high does not request again, and a falling input does not clear a pending request.
- R4: On a level-triggered line, the request bit follows the input. A low input clears it, and an acknowledge leaves it set.
- R5: A mask bit of 1 keeps a line from being chosen, but its request is still recorded. The lowest-numbered unmasked pending line is the candidate. `intr` is high when a candidate exists and no in-service line of the same or a lower number blocks it.
- R6: One cycle after `ack_req`, for a master line other than 2, `ack_valid` is 1 and `ack_vector` is the core base bits [7:3] joined with the line index. The in-service bit of that line is set unless auto end-of-interrupt is on.
- R7: When the master's candidate is line 2, the slave's candidate is acknowledged and its vector is returned. Master line 2 then sees a fresh edge once the slave has another unblocked candidate. The master's own in-service bit 2 still blocks that new edge until it is cleared.
- R8: An acknowledge returns `ack_valid` = 0 in two cases: the master has no candidate, or the acknowledge is forwarded to a slave that has none.
- R9: A command write with bits 4 and 3 both 0 is an end-of-interrupt, whose code is in bits [7:5]. Code 3'b011 clears the in-service bit selected by bits [2:0]. Code 3'b110 changes nothing. Any other code clears the lowest-numbered in-service bit.
- R10: A command write with bit 4 set clears requests, in-service bits and recorded levels, masks every line, turns auto end-of-interrupt on and selects request read-back. While the sequencer is not in `ST_RUN`, data writes do not touch the mask. In `ST_MODE`, bit 1 of the data write sets auto end-of-interrupt.
- R11: A command write with bit 4 = 0 and bit 3 = 1 sets the read-back source when bit 1 is 1: bit 0 = 1 selects in-service and bit 0 = 0 selects requests. The command location reads that source.
- R12: In the same command form, bit 6 = 1 sets special-mask mode to the value of bit 5. In that mode, in-service bits of masked lines do not block lower-priority lines.
- R13: Raw input 2 and the slave's pending flag share master line 2. Raw input 2 alone therefore raises `intr`, and acknowledging it yields `ack_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 16 | Raw request lines, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| intr | output | 1 | Interrupt pending toward the processor |
| ack_req | input | 1 | One-cycle acknowledge from the processor |
| ack_valid | output | 1 | Vector valid, one cycle after `ack_req` |
| ack_vector | output | 8 | Vector delivered with `ack_valid` |

## Verification
The bench holds an edge line high across an acknowledge and an end-of-interrupt. A design that samples levels instead of edges would request a second time. It acknowledges a level line and confirms the request survives, which catches a design that clears every acknowledged request. In the cascade, it completes one slave service while a second slave line waits. A design that fails to drop master line 2 on the forwarded acknowledge never sees the new edge and stalls. It also masks the slave line after master line 2 has latched, and expects an invalid acknowledge rather than a stale vector. The end-of-interrupt codes, special-mask unblocking and the re-initialisation sequence each get directed stimulus. Each scenario is followed by read-back of the request and in-service registers.

// File: rtl/irq16_pkg.sv
package irq16_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } cfg_st_t;

    localparam int ADDR_W       = 3;
    localparam int DATA_W       = 8;
    localparam int CASCADE_LINE = 2;

    localparam logic [ADDR_W-1:0] A_M_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_M_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_S_CMD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_S_DATA = 3'd3;
    localparam logic [ADDR_W-1:0] A_M_TRIG = 3'd4;
    localparam logic [ADDR_W-1:0] A_S_TRIG = 3'd5;

    localparam logic [2:0] EOI_SPECIFIC = 3'b011;
    localparam logic [2:0] EOI_NOP      = 3'b110;
endpackage

// File: rtl/irq16_trigger.sv
module irq16_trigger #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_hist,
    input  logic [LINES-1:0] lvl_in,
    input  logic [LINES-1:0] level_mode,
    output logic [LINES-1:0] set_vec,
    output logic [LINES-1:0] clr_vec
);
    logic [LINES-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (clr_hist) hist_q <= '0;
        else               hist_q <= lvl_in;
    end

    // rising edge for edge lines, any high level for level lines
    assign set_vec = lvl_in & (~hist_q | level_mode);
    assign clr_vec = ~lvl_in & level_mode;
endmodule

// File: rtl/irq16_core.sv
module irq16_core
    import irq16_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic                     data_wr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [LINES-1:0]         set_vec,
    input  logic [LINES-1:0]         clr_vec,
    input  logic [LINES-1:0]         level_mode,
    input  logic                     ack_take,
    output logic                     pend,
    output logic [$clog2(LINES)-1:0] cand_idx,
    output logic [DATA_W-1:0]        vector,
    output logic [LINES-1:0]         req_q,
    output logic [LINES-1:0]         srv_q,
    output logic [LINES-1:0]         mask_q,
    output logic                     rd_srv,
    output logic                     auto_eoi,
    output logic                     init_pulse
);
    localparam int IW = $clog2(LINES);

    cfg_st_t          st_q, st_d;
    logic [DATA_W-1:IW] base_q;
    logic             want_mode_q, smm_q;
    logic             is_init, is_sel, is_eoi;
    logic [LINES-1:0] active, cand_oh, srv_vis, srv_oh;
    logic [LINES-1:0] req_next, srv_next;

    assign is_init    = cmd_wr & wdata[4];
    assign is_sel     = cmd_wr & ~wdata[4] & wdata[3];
    assign is_eoi     = cmd_wr & ~wdata[4] & ~wdata[3];
    assign init_pulse = is_init;
    assign vector     = {base_q, cand_idx};

    // priority resolution
    always_comb begin
        active   = req_q & ~mask_q;
        cand_oh  = active & (~active + 1'b1);
        srv_vis  = smm_q ? (srv_q & ~mask_q) : srv_q;
        srv_oh   = srv_vis & (~srv_vis + 1'b1);
        pend     = (active != '0) && ((srv_vis == '0) || (srv_oh > cand_oh));
        cand_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (active[i]) cand_idx = IW'(i);
        end
    end

    // configuration sequencer: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  st_d = ST_RUN;
            ST_BASE: if (data_wr) st_d = ST_CASC;
            ST_CASC: if (data_wr) st_d = want_mode_q ? ST_MODE : ST_RUN;
            ST_MODE: if (data_wr) st_d = ST_RUN;
        endcase
        if (is_init) st_d = ST_BASE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // request and in-service next values
    always_comb begin
        req_next = req_q;
        if (ack_take && !level_mode[cand_idx]) req_next[cand_idx] = 1'b0;
        req_next = (req_next & ~clr_vec) | set_vec;
        srv_next = srv_q;
        if (ack_take && !auto_eoi) srv_next[cand_idx] = 1'b1;
        if (is_eoi) begin
            case (wdata[7:5])
                EOI_SPECIFIC: srv_next[wdata[IW-1:0]] = 1'b0;
                EOI_NOP:      srv_next = srv_next;
                default:      srv_next = srv_next & (srv_next - 1'b1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q       <= '0;
            srv_q       <= '0;
            mask_q      <= '1;
            base_q      <= '0;
            auto_eoi    <= 1'b0;
            want_mode_q <= 1'b0;
            rd_srv      <= 1'b0;
            smm_q       <= 1'b0;
        end else if (is_init) begin
            req_q       <= '0;
            srv_q       <= '0;
            mask_q      <= '1;
            auto_eoi    <= 1'b1;
            want_mode_q <= wdata[0];
            rd_srv      <= 1'b0;
            smm_q       <= 1'b0;
        end else begin
            req_q <= req_next;
            srv_q <= srv_next;
            if (data_wr) begin
                unique case (st_q)
                    ST_RUN:  mask_q   <= wdata[LINES-1:0];
                    ST_BASE: base_q   <= wdata[DATA_W-1:IW];
                    ST_CASC: ;
                    ST_MODE: auto_eoi <= wdata[1];
                endcase
            end
            if (is_sel && wdata[1]) rd_srv <= wdata[0];
            if (is_sel && wdata[6]) smm_q  <= wdata[5];
        end
    end
endmodule

// File: rtl/cascade_irq16.sv
module cascade_irq16
    import irq16_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               intr,
    input  logic               ack_req,
    output logic               ack_valid,
    output logic [DATA_W-1:0]  ack_vector
);
    localparam int IW = $clog2(LINES);

    logic [LINES-1:0]  m_trig_q, s_trig_q;
    logic [LINES-1:0]  m_lines, s_lines;
    logic [LINES-1:0]  m_set, m_clr, s_set, s_clr;
    logic [LINES-1:0]  m_req, m_srv, m_mask, s_req, s_srv, s_mask;
    logic [IW-1:0]     m_idx, s_idx;
    logic [DATA_W-1:0] m_vec, s_vec;
    logic              m_pend, s_pend, m_rd_srv, s_rd_srv, m_auto, s_auto;
    logic              m_init, s_init, m_take, s_take, fwd, line2_in;
    logic              m_cmd_wr, m_data_wr, s_cmd_wr, s_data_wr;

    assign m_cmd_wr  = wr_en && (addr == A_M_CMD);
    assign m_data_wr = wr_en && (addr == A_M_DATA);
    assign s_cmd_wr  = wr_en && (addr == A_S_CMD);
    assign s_data_wr = wr_en && (addr == A_S_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_trig_q <= '0;
            s_trig_q <= '0;
        end else if (wr_en) begin
            if (addr == A_M_TRIG) m_trig_q <= wdata[LINES-1:0];
            if (addr == A_S_TRIG) s_trig_q <= wdata[LINES-1:0];
        end
    end

    // acknowledge chaining
    assign m_take   = ack_req & m_pend;
    assign fwd      = m_take & (m_idx == IW'(CASCADE_LINE));
    assign s_take   = fwd & s_pend;
    assign line2_in = irq_in[CASCADE_LINE] | (s_pend & ~s_take);
    assign intr     = m_pend;

    always_comb begin
        m_lines               = irq_in[LINES-1:0];
        m_lines[CASCADE_LINE] = line2_in;
        s_lines               = irq_in[2*LINES-1:LINES];
    end

    irq16_trigger #(.LINES(LINES)) u_m_trig (
        .clk(clk), .rst_n(rst_n), .clr_hist(m_init), .lvl_in(m_lines),
        .level_mode(m_trig_q), .set_vec(m_set), .clr_vec(m_clr)
    );

    irq16_trigger #(.LINES(LINES)) u_s_trig (
        .clk(clk), .rst_n(rst_n), .clr_hist(s_init), .lvl_in(s_lines),
        .level_mode(s_trig_q), .set_vec(s_set), .clr_vec(s_clr)
    );

    irq16_core #(.LINES(LINES)) u_master (
        .clk(clk), .rst_n(rst_n), .cmd_wr(m_cmd_wr), .data_wr(m_data_wr),
        .wdata(wdata), .set_vec(m_set), .clr_vec(m_clr), .level_mode(m_trig_q),
        .ack_take(m_take), .pend(m_pend), .cand_idx(m_idx), .vector(m_vec),
        .req_q(m_req), .srv_q(m_srv), .mask_q(m_mask), .rd_srv(m_rd_srv),
        .auto_eoi(m_auto), .init_pulse(m_init)
    );

    irq16_core #(.LINES(LINES)) u_slave (
        .clk(clk), .rst_n(rst_n), .cmd_wr(s_cmd_wr), .data_wr(s_data_wr),
        .wdata(wdata), .set_vec(s_set), .clr_vec(s_clr), .level_mode(s_trig_q),
        .ack_take(s_take), .pend(s_pend), .cand_idx(s_idx), .vector(s_vec),
        .req_q(s_req), .srv_q(s_srv), .mask_q(s_mask), .rd_srv(s_rd_srv),
        .auto_eoi(s_auto), .init_pulse(s_init)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
            if (m_take && !fwd) begin
                ack_valid  <= 1'b1;
                ack_vector <= m_vec;
            end else if (s_take) begin
                ack_valid  <= 1'b1;
                ack_vector <= s_vec;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_M_CMD:  rdata[LINES-1:0] = m_rd_srv ? m_srv : m_req;
            A_M_DATA: rdata[LINES-1:0] = m_mask;
            A_S_CMD:  rdata[LINES-1:0] = s_rd_srv ? s_srv : s_req;
            A_S_DATA: rdata[LINES-1:0] = s_mask;
            A_M_TRIG: rdata[LINES-1:0] = m_trig_q;
            A_S_TRIG: rdata[LINES-1:0] = s_trig_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq16_checker.sv
module irq16_checker #(
    parameter int LINES = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ack_req,
    input logic                     ack_valid,
    input logic                     intr,
    input logic [LINES-1:0]         m_req,
    input logic [LINES-1:0]         m_mask,
    input logic [LINES-1:0]         m_srv,
    input logic [$clog2(LINES)-1:0] m_idx,
    input logic                     m_take,
    input logic                     m_auto,
    input logic                     m_cmd_wr,
    input logic                     fwd,
    input logic                     s_pend,
    input logic                     s_take,
    input logic                     s_auto,
    input logic                     s_cmd_wr,
    input logic [LINES-1:0]         s_srv,
    input logic [$clog2(LINES)-1:0] s_idx,
    input logic [LINES-1:0]         s_req,
    input logic [LINES-1:0]         s_trig_q,
    input logic [LINES-1:0]         s_lines
);
    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_req));

    a_r8_no_candidate_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !intr) |=> !ack_valid);

    a_r5_intr_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((m_req & ~m_mask) != '0));

    a_r6_master_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (m_take && !m_auto && !m_cmd_wr) |=> m_srv[$past(m_idx)]);

    a_r7_slave_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (s_take && !s_auto && !s_cmd_wr) |=> s_srv[$past(s_idx)]);

    a_r7_forward_gives_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && s_pend) |=> ack_valid);

    a_r4_level_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_req & $past(s_trig_q & ~s_lines)) == '0));
endmodule

bind cascade_irq16 irq16_checker #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_valid(ack_valid),
    .intr(intr), .m_req(m_req), .m_mask(m_mask), .m_srv(m_srv), .m_idx(m_idx),
    .m_take(m_take), .m_auto(m_auto), .m_cmd_wr(m_cmd_wr), .fwd(fwd),
    .s_pend(s_pend), .s_take(s_take), .s_auto(s_auto), .s_cmd_wr(s_cmd_wr),
    .s_srv(s_srv), .s_idx(s_idx), .s_req(s_req), .s_trig_q(s_trig_q),
    .s_lines(s_lines)
);

// File: tb/tb_cascade_irq16.sv
`timescale 1ns/100ps
module tb_cascade_irq16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        intr;
    logic        ack_req = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cascade_irq16 dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .intr(intr), .ack_req(ack_req),
        .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
        addr = a;
        #0.5;
        chk(tag, rdata, exp);
    endtask

    task automatic ack(logic exp_v, logic [7:0] exp_vec, string tag);
        ack_req = 1'b1;
        tick(1);
        ack_req = 1'b0;
        chk({tag, " valid"}, {7'd0, ack_valid}, {7'd0, exp_v});
        if (exp_v) chk({tag, " vector"}, ack_vector, exp_vec);
    endtask

    task automatic init_core(logic [2:0] ca, logic [2:0] da, logic [7:0] base,
                             logic [7:0] mode);
        wr(ca, 8'h11);
        rd(da, 8'hFF, "R10 init masks all");
        wr(da, base);
        rd(da, 8'hFF, "R10 base write leaves mask");
        wr(da, 8'h04);
        wr(da, mode);
        wr(da, 8'h00);
        rd(da, 8'h00, "R10 mask write after sequence");
    endtask

    task automatic t_reset();
        rd(3'd1, 8'hFF, "R1 master mask");
        rd(3'd3, 8'hFF, "R1 slave mask");
        rd(3'd4, 8'h00, "R1 master trigger");
        rd(3'd5, 8'h00, "R1 slave trigger");
        chk("R1 intr", {7'd0, intr}, 8'h00);
        chk("R1 ack_valid", {7'd0, ack_valid}, 8'h00);
        wr(3'd5, 8'h5A);
        rd(3'd5, 8'h5A, "R2 trigger readback");
        wr(3'd5, 8'h00);
        rd(3'd5, 8'h00, "R2 trigger cleared");
    endtask

    task automatic t_edge();
        irq_in[5] = 1'b1; tick(2);
        chk("R3 edge raises intr", {7'd0, intr}, 8'h01);
        wr(3'd0, 8'h0A);
        rd(3'd0, 8'h20, "R11 request readback");
        ack(1'b1, 8'h25, "R6 master vector");
        wr(3'd0, 8'h0B);
        rd(3'd0, 8'h20, "R11 in-service readback");
        wr(3'd0, 8'h0A);
        rd(3'd0, 8'h00, "R3 ack clears edge request");
        wr(3'd0, 8'h20); tick(2);
        chk("R3 held high no second request", {7'd0, intr}, 8'h00);
        irq_in[5] = 1'b0; tick(2);
        chk("R3 fall no request", {7'd0, intr}, 8'h00);
        irq_in[5] = 1'b1; tick(2);
        chk("R3 new edge requests", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h25, "R6 second vector");
        wr(3'd0, 8'h20);
        irq_in[5] = 1'b0; tick(1);
    endtask

    task automatic t_level();
        wr(3'd4, 8'h40);
        rd(3'd4, 8'h40, "R2 master trigger readback");
        irq_in[6] = 1'b1; tick(2);
        rd(3'd0, 8'h40, "R4 level request");
        ack(1'b1, 8'h26, "R4 level vector");
        rd(3'd0, 8'h40, "R4 ack keeps level request");
        irq_in[6] = 1'b0; tick(2);
        rd(3'd0, 8'h00, "R4 low clears request");
        wr(3'd0, 8'h20);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_prio();
        irq_in[4] = 1'b1; irq_in[1] = 1'b1; tick(2);
        ack(1'b1, 8'h21, "R5 lowest line wins");
        chk("R5 blocked by higher in service", {7'd0, intr}, 8'h00);
        wr(3'd0, 8'h20); tick(1);
        chk("R5 unblocked after eoi", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h24, "R5 next vector");
        wr(3'd0, 8'h20);
        irq_in[4] = 1'b0; irq_in[1] = 1'b0;
        wr(3'd1, 8'h10);
        irq_in[4] = 1'b1; tick(2);
        chk("R5 masked line silent", {7'd0, intr}, 8'h00);
        rd(3'd0, 8'h10, "R5 masked request recorded");
        wr(3'd1, 8'h00); tick(1);
        chk("R5 unmask raises intr", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h24, "R5 unmasked vector");
        irq_in[3] = 1'b1; tick(2);
        chk("R5 higher line preempts", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h23, "R5 preempt vector");
        irq_in[1] = 1'b1; tick(2);
        ack(1'b1, 8'h21, "R5 nested vector");
        wr(3'd0, 8'h0B);
        rd(3'd0, 8'h1A, "R11 nested in-service");
        wr(3'd0, 8'h63);
        rd(3'd0, 8'h12, "R9 specific eoi");
        wr(3'd0, 8'hC0);
        rd(3'd0, 8'h12, "R9 no-op code");
        wr(3'd0, 8'h20);
        rd(3'd0, 8'h10, "R9 nonspecific lowest");
        wr(3'd0, 8'h20);
        rd(3'd0, 8'h00, "R9 all cleared");
        wr(3'd0, 8'h0A);
        irq_in[1] = 1'b0; irq_in[3] = 1'b0; irq_in[4] = 1'b0; tick(1);
    endtask

    task automatic t_smm();
        irq_in[3] = 1'b1; tick(2);
        ack(1'b1, 8'h23, "R12 first vector");
        wr(3'd1, 8'h08);
        irq_in[5] = 1'b1; tick(2);
        chk("R12 normal mode blocks", {7'd0, intr}, 8'h00);
        wr(3'd0, 8'h68); tick(1);
        chk("R12 special mask unblocks", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h25, "R12 vector");
        wr(3'd0, 8'h48);
        wr(3'd0, 8'h63);
        wr(3'd0, 8'h65);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h0B);
        rd(3'd0, 8'h00, "R9 specific eoi pair");
        wr(3'd0, 8'h0A);
        irq_in[3] = 1'b0; irq_in[5] = 1'b0; tick(1);
    endtask

    task automatic t_cascade();
        irq_in[11] = 1'b1; irq_in[13] = 1'b1; tick(3);
        chk("R7 slave raises intr", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h73, "R7 slave vector");
        wr(3'd2, 8'h0B);
        rd(3'd2, 8'h08, "R7 slave in-service");
        wr(3'd2, 8'h20); tick(3);
        chk("R7 master line 2 still in service", {7'd0, intr}, 8'h00);
        wr(3'd0, 8'h20); tick(1);
        chk("R7 second slave request reaches", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h75, "R7 second slave vector");
        rd(3'd2, 8'h20, "R7 second in-service");
        wr(3'd2, 8'h20);
        wr(3'd0, 8'h20);
        wr(3'd2, 8'h0A);
        irq_in[11] = 1'b0; irq_in[13] = 1'b0; tick(1);
    endtask

    task automatic t_fwd_none();
        ack(1'b0, 8'h00, "R8 nothing pending");
        irq_in[12] = 1'b1; tick(3);
        chk("R8 slave line pending", {7'd0, intr}, 8'h01);
        wr(3'd3, 8'h10); tick(1);
        ack(1'b0, 8'h00, "R8 slave withdrew");
        wr(3'd0, 8'h20);
        wr(3'd3, 8'h00); tick(3);
        chk("R8 unmasked slave returns", {7'd0, intr}, 8'h01);
        ack(1'b1, 8'h74, "R8 later vector");
        wr(3'd2, 8'h20);
        wr(3'd0, 8'h20);
        irq_in[12] = 1'b0; tick(1);
    endtask

    task automatic t_raw2();
        irq_in[2] = 1'b1; tick(2);
        chk("R13 raw line 2 raises intr", {7'd0, intr}, 8'h01);
        ack(1'b0, 8'h00, "R13 forwarded without slave");
        wr(3'd0, 8'h20);
        irq_in[2] = 1'b0; tick(1);
    endtask

    task automatic t_reinit();
        irq_in[7] = 1'b1; tick(2);
        irq_in[7] = 1'b0;
        wr(3'd0, 8'h11);
        rd(3'd0, 8'h00, "R10 init clears requests");
        wr(3'd1, 8'h20);
        wr(3'd1, 8'h04);
        wr(3'd1, 8'h03);
        wr(3'd1, 8'h00);
        irq_in[0] = 1'b1; tick(2);
        ack(1'b1, 8'h20, "R10 auto mode vector");
        wr(3'd0, 8'h0B);
        rd(3'd0, 8'h00, "R10 auto eoi leaves no in-service");
        irq_in[0] = 1'b0; tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        init_core(3'd0, 3'd1, 8'h20, 8'h01);
        init_core(3'd2, 3'd3, 8'h70, 8'h01);
        t_edge();
        t_level();
        t_prio();
        t_smm();
        t_cascade();
        t_fwd_none();
        t_raw2();
        t_reinit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule